// File: doc/BRIEF.md
# Three-Phase 120-Degree Firing Sequencer

This block drives the three firing lines that feed the input stage of a six-switch three-phase bridge. A prescaler divides the system clock into a slow timing tick. A single cycle-position counter counts these ticks. The counter is compared against six cumulative end points, one for each state of a six-state machine. The machine alternates all-off gaps with conduction windows. In each conduction window exactly one line is high, and the active line steps to the next phase every 120 degrees.

With the default parameters, a 100 MHz clock divided by 1000 gives a 10 µs tick. The end points are 269, 669, 938, 1338, 1607 and 2007 ticks. Each gap therefore lasts about 2.7 ms and each window lasts 4 ms, and the whole cycle is about 20 ms, close to 50 Hz. The sequence repeats with no end. A synchronous reset restarts it from the first gap.

Top module: `phase_fire_seq`

## Requirements
- R1: One timing tick occurs every TICK_DIV clock cycles. The state machine and the cycle counter change only on a tick, so every interval lasts a whole multiple of TICK_DIV clocks.
- R2: While rst is high, the output reads 3'b000 from the first clock edge that samples rst, and it stays at that value until reset is released.
- R3: After reset the first gap lasts END0 ticks. Each later state k lasts END_k minus END_(k-1) ticks.
- R4: Output encoding: the three gap states drive 3'b000. The first window drives 3'b001, the second drives 3'b010 and the third drives 3'b100 (bit i fires phase i).
- R5: On every clock cycle at most one output bit is high.
- R6: The output never moves directly from one high line to a different high line. An all-low gap always separates two conduction windows.
- R7: When the count reaches END5, the counter clears and the machine returns to the first gap. The next cycle repeats the same order and durations.
- R8: A reset asserted in the middle of a cycle drops the output to 3'b000 on the next edge. After release the full first gap of END0 ticks is timed again before phase 0 fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_o | output | 3 | Firing lines, bit i drives phase i |

## Verification
Some properties are checked on every cycle. At most one line is high at a time. One high line never gives way directly to another. The state holds between counter hits. The last window always wraps back to the first gap. The prescaler and the cycle counter stay below their limits. Other behaviour shows only in the bench scenarios. These cover the exact length of each interval in clocks, the encoding and rotation order of the three phases, and the repeat of the second cycle. They also cover the restart of the first gap after a reset in mid-cycle.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int NUM_STATES = 6;
    localparam int NUM_LINES  = 3;

    typedef enum logic [2:0] {
        ST_GAP_A = 3'd0,
        ST_ON_A  = 3'd1,
        ST_GAP_B = 3'd2,
        ST_ON_B  = 3'd3,
        ST_GAP_C = 3'd4,
        ST_ON_C  = 3'd5
    } fire_st_e;

    // Line pattern that belongs to each state
    function automatic logic [NUM_LINES-1:0] fire_decode(input fire_st_e st);
        logic [NUM_LINES-1:0] pat;
        case (st)
            ST_ON_A: pat = 3'b001;
            ST_ON_B: pat = 3'b010;
            ST_ON_C: pat = 3'b100;
            default: pat = 3'b000;
        endcase
        return pat;
    endfunction

    function automatic fire_st_e fire_next(input fire_st_e st);
        fire_st_e nx;
        case (st)
            ST_GAP_A: nx = ST_ON_A;
            ST_ON_A:  nx = ST_GAP_B;
            ST_GAP_B: nx = ST_ON_B;
            ST_ON_B:  nx = ST_GAP_C;
            ST_GAP_C: nx = ST_ON_C;
            default:  nx = ST_GAP_A;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/pfs_prescaler.sv
module pfs_prescaler #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_s;

    pre_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == LAST) r_d.cnt = '0;
        else                 r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign tick_o = (r_q.cnt == LAST);

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(r_q.cnt) < TICK_DIV); // R1

    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (r_q.cnt == '0) || (TICK_DIV == 1)); // R1
endmodule

// File: rtl/pfs_cycle_pos.sv
module pfs_cycle_pos #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    input  logic          wrap_i,
    output logic [CW-1:0] pos_o,
    output logic          hit_o
);
    typedef struct packed {
        logic [CW-1:0] pos;
    } pos_s;

    pos_s r_d, r_q;
    logic [CW-1:0] pos_inc;

    assign pos_inc = r_q.pos + 1'b1;
    assign hit_o   = tick_i && (pos_inc == limit_i);

    always_comb begin
        r_d = r_q;
        if (tick_i) begin
            if (hit_o && wrap_i) r_d.pos = '0;
            else                 r_d.pos = pos_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign pos_o = r_q.pos;

    AST_POS_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        r_q.pos < limit_i); // R3

    AST_POS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(r_q.pos)); // R1
endmodule

// File: rtl/pfs_state_ctl.sv
module pfs_state_ctl
    import pfs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hit_i,
    output fire_st_e             state_o,
    output logic                 wrap_o,
    output logic [NUM_LINES-1:0] phase_o
);
    typedef struct packed {
        fire_st_e             st;
        logic [NUM_LINES-1:0] lines;
    } ctl_s;

    ctl_s r_d, r_q;

    // transition process
    always_comb begin
        r_d.st = r_q.st;
        if (hit_i) r_d.st = fire_next(r_q.st);
    end

    // output decode process, registered alongside the state
    always_comb begin
        r_d.lines = fire_decode(r_d.st);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= ST_GAP_A;
            r_q.lines <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign wrap_o  = (r_q.st == ST_ON_C);
    assign phase_o = r_q.lines;

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_o)); // R5

    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (rst)
        (phase_o != '0) && ($past(phase_o) != '0) |-> phase_o == $past(phase_o)); // R6

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        !hit_i |=> $stable(r_q.st)); // R3

    AST_WRAP_HOME: assert property (@(posedge clk) disable iff (rst)
        hit_i && wrap_o |=> (r_q.st == ST_GAP_A) && (phase_o == '0)); // R7
endmodule

// File: rtl/phase_fire_seq.sv
module phase_fire_seq
    import pfs_pkg::*;
#(
    parameter int TICK_DIV = 1000,
    parameter int END0     = 269,
    parameter int END1     = 669,
    parameter int END2     = 938,
    parameter int END3     = 1338,
    parameter int END4     = 1607,
    parameter int END5     = 2007
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] phase_o
);
    localparam int CW = $clog2(END5 + 1);

    logic          tick;
    logic          hit;
    logic          wrap;
    logic [CW-1:0] pos;
    logic [CW-1:0] limit;
    fire_st_e      state;

    pfs_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    // cumulative end point of the current state
    always_comb begin
        case (state)
            ST_GAP_A: limit = CW'(END0);
            ST_ON_A:  limit = CW'(END1);
            ST_GAP_B: limit = CW'(END2);
            ST_ON_B:  limit = CW'(END3);
            ST_GAP_C: limit = CW'(END4);
            default:  limit = CW'(END5);
        endcase
    end

    pfs_cycle_pos #(.CW(CW)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .limit_i (limit),
        .wrap_i  (wrap),
        .pos_o   (pos),
        .hit_o   (hit)
    );

    pfs_state_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hit),
        .state_o (state),
        .wrap_o  (wrap),
        .phase_o (phase_o)
    );

    AST_HIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        hit |-> tick); // R1

    AST_CYCLE_RESTART: assert property (@(posedge clk) disable iff (rst)
        hit && wrap |=> pos == '0); // R7
endmodule

// File: tb/sim_phase_fire_seq.sv
module sim_phase_fire_seq;
    localparam int DIV = 3;
    localparam int E0 = 4, E1 = 9, E2 = 13, E3 = 18, E4 = 22, E5 = 27;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ph;
    int total = 0;
    int bad = 0;
    int oh_bad = 0;
    int swap_bad = 0;
    logic [2:0] prev_ph = 3'b000;

    always #10 clk = ~clk;

    phase_fire_seq #(.TICK_DIV(DIV), .END0(E0), .END1(E1), .END2(E2),
                     .END3(E3), .END4(E4), .END5(E5)) u0 (
        .clk(clk), .rst(rst), .phase_o(ph));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_len(input logic [2:0] val, output int n);
        n = 0;
        while (ph == val && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // R5 / R6 monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (!$onehot0(ph)) oh_bad++;
            if (ph != 3'b000 && prev_ph != 3'b000 && ph != prev_ph) swap_bad++;
        end
        prev_ph = ph;
    end

    function automatic logic [2:0] code_of(input int k);
        case (k)
            1: return 3'b001;
            3: return 3'b010;
            5: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic int ticks_of(input int k);
        case (k)
            0: return E0;
            1: return E1 - E0;
            2: return E2 - E1;
            3: return E3 - E2;
            4: return E4 - E3;
            default: return E5 - E4;
        endcase
    endfunction

    task automatic t_reset_hold();
        rst = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ph != 3'b000) begin
                check(0, "R2", "output during reset", ph, 0);
                return;
            end
        end
        check(1, "R2", "output during reset", ph, 0);
    endtask

    task automatic release_and_first_gap(input string req);
        int n;
        rst = 1'b0;
        @(negedge clk);
        run_len(3'b000, n);
        // first sample taken after the first edge, so one clock short
        check(n == E0 * DIV - 1, req, "first gap length in clocks (R1)", n, E0 * DIV - 1);
        check(ph == 3'b001, req, "first window code", ph, 1);
    endtask

    // walks windows and gaps k = 1..5 starting at the first window
    task automatic walk_rest(input string tag);
        int n;
        for (int k = 1; k <= 5; k++) begin
            check(ph == code_of(k), "R4", {tag, " state code"}, ph, code_of(k));
            run_len(code_of(k), n);
            check(n == ticks_of(k) * DIV, "R3", {tag, " state length"}, n, ticks_of(k) * DIV);
        end
    endtask

    task automatic t_first_cycle();
        release_and_first_gap("R3");
        walk_rest("cycle1");
    endtask

    task automatic t_second_cycle();
        int n;
        check(ph == 3'b000, "R7", "wrap to first gap", ph, 0);
        run_len(3'b000, n);
        check(n == E0 * DIV, "R7", "repeated first gap", n, E0 * DIV);
        walk_rest("cycle2");
    endtask

    task automatic t_mid_reset();
        int guard = 0;
        while (ph != 3'b010 && guard < 500) begin
            guard++;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(ph == 3'b010, "R8", "inside second window", ph, 2);
        rst = 1'b1;
        @(negedge clk);
        check(ph == 3'b000, "R8", "output after mid-cycle reset", ph, 0);
        @(negedge clk);
        release_and_first_gap("R8");
    endtask

    task automatic t_monitors();
        check(oh_bad == 0, "R5", "cycles with more than one line", oh_bad, 0);
        check(swap_bad == 0, "R6", "direct line swaps", swap_bad, 0);
    endtask

    bit done = 0;

    initial begin
        t_reset_hold();
        t_first_cycle();
        t_second_cycle();
        t_mid_reset();
        walk_rest("after reset");
        t_monitors();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule